// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target (256 x 8)

This block models a two-wire serial EEPROM target that holds 256 bytes. A fast system clock oversamples an externally driven serial clock line and an open-drain data line. The block decodes bus start and stop conditions and answers a device address word. It accepts an 8-bit word address. It can then store one byte or a run of bytes inside an 8-byte page, or return bytes from the array. The block never drives the data line high. It only asserts an output enable that pulls the line low, and board logic or the bench forms the wired-AND line.

Writes are first collected in a page buffer. They are committed to the array only when a stop condition closes the write. That stop also starts a self-timed busy period, whose length is set in system clocks. While the busy period runs, the target ignores its device address. A write-protect input sampled at the stop throws the buffered bytes away, although every byte was acknowledged. Reads can start at the current address, at a random address reached through a dummy write followed by a repeated start, or run on sequentially while the master acknowledges.

Top module: `twi_eeprom_target`

## Requirements
- R1: During and right after a synchronous reset, `sda_oe` is 0 and the target waits for a start condition.
- R2: A start condition (data falls while clock is high) restarts the address phase from any state, and a partly received byte is dropped. A stop condition (data rises while clock is high) returns the target to idle. A write that stored no complete data byte starts no busy period.
- R3: `sda_oe` changes only after a falling edge of the clock, or after a start or stop condition. It never changes in the middle of a clock-high period.
- R4: The device address word is sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `dev_sel`. Bit 0 is 1 for read and 0 for write. On a match the target pulls data low during the ninth clock. On a mismatch it leaves data released and waits for a stop.
- R5: A write with the word address followed by one data byte has each byte acknowledged. That byte appears at that address once the stop-triggered commit is done.
- R6: In a multi-byte write, bits 2..0 of the address increment and wrap inside the 8-byte page given by bits 7..3. Bytes past the page end overwrite the start of the same page.
- R7: A partial page write changes only the bytes it sent. The other bytes of the page keep their values.
- R8: If `wp_hold` is 1 when the closing stop arrives, every byte is still acknowledged, but the array is unchanged and no busy period starts.
- R9: A stop that ends a write with stored data starts a busy period of `WR_CLKS` system clocks. During that period the device address is not acknowledged. After it, the address is acknowledged again.
- R10: A random read returns the byte at the word address loaded by the dummy write, after a repeated start and a read device address.
- R11: While the master acknowledges each byte, a read continues with the next address. The address rolls over from 255 to 0.
- R12: A current-address read returns the byte one past the last byte read.
- R13: When the master does not acknowledge a read byte, the target releases data and keeps it released for all further clocks until a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Data line level (wired-AND of all drivers) |
| dev_sel | input | 3 | Hardwired device select bits compared with address bits 3..1 |
| wp_hold | input | 1 | Write protect; 1 blocks the commit of buffered bytes |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
On every cycle the embedded properties check several things. The output enable only moves after a clock fall or a bus condition. A busy period only begins one cycle after a stop. A protected stop never starts one. The address acknowledge is never given while busy, and it is only given for a matching address word. Only the bench's bus scenarios can show the data-level results. These are page wrap and partial-page retention, the ignored protected write, random, current-address and rolled-over sequential reads, the aborted byte on a repeated start, and the released line after a master's missing acknowledge.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_WADDR,
    S_WADDR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RD_ACK,
    S_WAIT_STOP
  } twi_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         SEL_W    = 3;

endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  // Idle bus is high on both lines, so reset to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
      scl_p <= scl_q[SYNC_STAGES-1];
      sda_p <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_lvl   = sda_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/twi_byte_store.sv
module twi_byte_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // One write port and one registered read port, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 8,       // word address width, at most 8
  parameter int PAGE_BYTES  = 8,
  parameter int WR_CLKS     = 625000,  // busy length in system clocks, > PAGE_BYTES
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic             wp_hold,
  output logic             sda_oe
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int BUSY_W = $clog2(WR_CLKS + 1);

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  twi_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_state_e              state;
  logic [7:0]              sh;
  logic [3:0]              cnt;
  logic [ADDR_W-1:0]       addr;
  logic                    is_read, mack;
  logic [7:0]              pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]   pmask;
  logic [PAGE_W-1:0]       page;
  logic                    busy;
  logic [BUSY_W-1:0]       bcnt;
  logic [OFS_W:0]          cidx;
  logic [7:0]              rdata;
  logic                    mem_we, take_byte, on_bus;

  assign on_bus    = ~start_det & ~stop_det;
  assign take_byte = on_bus && state == S_WDATA && scl_fall && cnt == 4'd8;
  assign mem_we    = busy && !cidx[OFS_W] && pmask[cidx[OFS_W-1:0]];

  twi_byte_store #(.AW(ADDR_W), .DW(8)) u_store (
    .clk(clk), .we(mem_we),
    .waddr({page, cidx[OFS_W-1:0]}), .wdata(pbuf[cidx[OFS_W-1:0]]),
    .raddr(addr), .rdata(rdata)
  );

  // Page buffer: plain storage, no reset needed
  always_ff @(posedge clk) begin
    if (take_byte) pbuf[addr[OFS_W-1:0]] <= sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      sda_oe  <= 1'b0;
      sh      <= '0;
      cnt     <= '0;
      addr    <= '0;
      is_read <= 1'b0;
      mack    <= 1'b0;
      pmask   <= '0;
      page    <= '0;
      busy    <= 1'b0;
      bcnt    <= '0;
      cidx    <= '0;
    end else begin
      // Self-timed commit: one buffered byte per clock, then wait out the rest
      if (busy) begin
        if (!cidx[OFS_W]) cidx <= cidx + 1'b1;
        if (bcnt == BUSY_W'(WR_CLKS - 1)) begin
          busy  <= 1'b0;
          pmask <= '0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end

      if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
        if (!busy && |pmask) begin
          if (!wp_hold) begin
            busy <= 1'b1;
            bcnt <= '0;
            cidx <= '0;
          end else begin
            pmask <= '0;
          end
        end
      end else if (start_det) begin
        state  <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_WADDR, S_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= 1'b1;
              if (state == S_DEV) begin
                if (sh[7:4] == DEV_TYPE && sh[3:1] == dev_sel && !busy) begin
                  is_read <= sh[0];
                  state   <= S_DEV_ACK;
                end else begin
                  sda_oe <= 1'b0;
                  state  <= S_WAIT_STOP;
                end
              end else if (state == S_WADDR) begin
                addr  <= sh[ADDR_W-1:0];
                pmask <= '0;
                state <= S_WADDR_ACK;
              end else begin
                pmask[addr[OFS_W-1:0]] <= 1'b1;
                page  <= addr[ADDR_W-1:OFS_W];
                addr  <= {addr[ADDR_W-1:OFS_W], addr[OFS_W-1:0] + 1'b1};
                state <= S_WDATA_ACK;
              end
            end
          end
          S_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_read) begin
                sh     <= rdata;
                sda_oe <= ~rdata[7];
                addr   <= addr + 1'b1;
                state  <= S_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_WADDR;
              end
            end
          end
          S_WADDR_ACK, S_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_WDATA;
            end
          end
          S_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= S_RD_ACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                sh     <= rdata;
                sda_oe <= ~rdata[7];
                addr   <= addr + 1'b1;
                cnt    <= '0;
                state  <= S_RDATA;
              end else begin
                state <= S_WAIT_STOP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: output enable moves only after a clock fall or a bus condition
  a_r3_oe_moves_after_fall: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R4: an address acknowledge is only given for a matching address word
  a_r4_ack_only_on_match: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEV_ACK && sda_oe) |-> (sh[7:1] == {DEV_TYPE, dev_sel}));

  // R9: the busy period starts only one cycle after a stop
  a_r9_busy_from_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  // R9: no address acknowledge while busy
  a_r9_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> state != S_DEV_ACK);

  // R8: a protected stop never starts a busy period
  a_r8_wp_no_busy: assert property (@(posedge clk) disable iff (rst)
    (stop_det && wp_hold && !busy) |=> !busy);

endmodule

// File: tb/tb_twi_eeprom_target.sv
module tb_twi_eeprom_target;

  localparam int WR   = 2000;
  localparam int Q    = 8;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [15:0] VEC [0:5] = '{16'h0011, 16'h0122, 16'h7F33,
                                        16'h8044, 16'hC555, 16'hFF66};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_drv & ~sda_oe;

  always #4 clk = ~clk;

  twi_eeprom_target #(.WR_CLKS(WR)) dut (
    .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_line),
    .dev_sel(SEL), .wp_hold(wp), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int r3_viol = 0;
  logic prev_oe = 1'b0;

  logic [7:0] model [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // R3 monitor: output enable must hold while the clock is high
  always @(negedge clk) begin
    if (!rst && scl_drv && sda_oe != prev_oe) r3_viol++;
    prev_oe <= sda_oe;
  end

  task automatic qwait; repeat (Q) @(negedge clk); endtask

  task automatic bstart;
    sda_drv = 1'b1; qwait; scl_drv = 1'b1; qwait;
    sda_drv = 1'b0; qwait; scl_drv = 1'b0; qwait;
  endtask

  task automatic bstop;
    sda_drv = 1'b0; qwait; scl_drv = 1'b1; qwait; sda_drv = 1'b1; qwait;
  endtask

  task automatic tx_bit(input logic b);
    sda_drv = b; qwait; scl_drv = 1'b1; qwait; scl_drv = 1'b0; qwait;
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) tx_bit(b[i]);
    sda_drv = 1'b1; qwait; scl_drv = 1'b1; qwait;
    ack = ~sda_line;
    scl_drv = 1'b0; qwait;
  endtask

  task automatic rx_byte(input logic give_ack, output logic [7:0] d);
    sda_drv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qwait; scl_drv = 1'b1; qwait;
      d = {d[6:0], sda_line};
      scl_drv = 1'b0;
    end
    qwait;
    tx_bit(~give_ack);
    sda_drv = 1'b1;
  endtask

  // Write n bytes from wbuf starting at a, model updated unless protected
  task automatic do_write(input logic [7:0] a, input int n, input bit wait_done,
                          input string req);
    logic ack;
    bit all_ack;
    all_ack = 1'b1;
    bstart;
    tx_byte({4'b1010, SEL, 1'b0}, ack); all_ack &= ack;
    tx_byte(a, ack); all_ack &= ack;
    for (int i = 0; i < n; i++) begin
      tx_byte(wbuf[i], ack); all_ack &= ack;
      if (!wp) model[{a[7:3], 3'(a[2:0] + i)}] = wbuf[i];
    end
    bstop;
    check({req, " write acks"}, int'(all_ack), 1);
    if (wait_done) repeat (WR + 50) @(negedge clk);
  endtask

  // Read n bytes into rbuf; random selects a dummy write of the address first
  task automatic do_read(input bit random, input logic [7:0] a, input int n,
                         input string req);
    logic ack;
    bit all_ack;
    all_ack = 1'b1;
    bstart;
    if (random) begin
      tx_byte({4'b1010, SEL, 1'b0}, ack); all_ack &= ack;
      tx_byte(a, ack); all_ack &= ack;
      bstart;
    end
    tx_byte({4'b1010, SEL, 1'b1}, ack); all_ack &= ack;
    for (int i = 0; i < n; i++) rx_byte(i < n - 1, rbuf[i]);
    bstop;
    check({req, " read acks"}, int'(all_ack), 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic ack;
    logic [7:0] d;
    int hold_viol;
    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 oe in reset", int'(sda_oe), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 oe after reset", int'(sda_oe), 0);

    // Vector table: byte write then random read back (R5, R10)
    for (int i = 0; i < 6; i++) begin
      wbuf[0] = VEC[i][7:0];
      do_write(VEC[i][15:8], 1, 1'b1, "R5");
      do_read(1'b1, VEC[i][15:8], 1, "R10");
      check("R5 R10 readback", int'(rbuf[0]), int'(VEC[i][7:0]));
    end

    // R4: mismatching select bits and wrong type nibble are not acknowledged
    bstart; tx_byte({4'b1010, 3'b100, 1'b0}, ack); bstop;
    check("R4 wrong select", int'(ack), 0);
    bstart; tx_byte({4'b1011, SEL, 1'b0}, ack); bstop;
    check("R4 wrong type", int'(ack), 0);
    bstart; tx_byte({4'b1010, SEL, 1'b0}, ack); bstop;
    check("R4 match", int'(ack), 1);

    // R6: fill page 0x10, then 4 bytes from 0x16 wrap to 0x10/0x11
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(8'h10, 8, 1'b1, "R6");
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hB0 + 8'(i);
    do_write(8'h16, 4, 1'b1, "R6");
    do_read(1'b1, 8'h10, 8, "R6");
    for (int i = 0; i < 8; i++) check("R6 page wrap", int'(rbuf[i]), int'(model[8'h10 + i]));
    check("R6 wrapped byte", int'(rbuf[0]), 'hB2);

    // R7: partial page write keeps the rest of the page
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h30 + 8'(i);
    do_write(8'h08, 8, 1'b1, "R7");
    wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
    do_write(8'h0A, 2, 1'b1, "R7");
    do_read(1'b1, 8'h08, 8, "R7");
    for (int i = 0; i < 8; i++) check("R7 partial", int'(rbuf[i]), int'(model[8'h08 + i]));
    check("R7 untouched byte", int'(rbuf[7]), 'h37);

    // R8: protected write is acknowledged but changes nothing, no busy
    wbuf[0] = 8'h5A;
    do_write(8'h30, 1, 1'b1, "R8");
    wp = 1'b1;
    wbuf[0] = 8'hA5;
    do_write(8'h30, 1, 1'b0, "R8");
    wp = 1'b0;
    bstart; tx_byte({4'b1010, SEL, 1'b0}, ack); bstop;
    check("R8 no busy after protected stop", int'(ack), 1);
    do_read(1'b1, 8'h30, 1, "R8");
    check("R8 array unchanged", int'(rbuf[0]), 'h5A);

    // R9: busy window NACKs the address, ACK after it ends
    wbuf[0] = 8'h77;
    do_write(8'h40, 1, 1'b0, "R9");
    bstart; tx_byte({4'b1010, SEL, 1'b0}, ack); bstop;
    check("R9 nack while busy", int'(ack), 0);
    repeat (WR + 50) @(negedge clk);
    bstart; tx_byte({4'b1010, SEL, 1'b0}, ack); bstop;
    check("R9 ack after busy", int'(ack), 1);
    do_read(1'b1, 8'h40, 1, "R9");
    check("R9 committed", int'(rbuf[0]), 'h77);

    // R11: sequential read rolls over 0xFF -> 0x00
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    do_write(8'hFE, 2, 1'b1, "R11");
    do_read(1'b1, 8'hFE, 3, "R11");
    check("R11 byte FE", int'(rbuf[0]), 'hE1);
    check("R11 byte FF", int'(rbuf[1]), 'hE2);
    check("R11 rollover 00", int'(rbuf[2]), int'(model[0]));

    // R12: current address read continues at 0x01
    do_read(1'b0, 8'h00, 1, "R12");
    check("R12 current addr", int'(rbuf[0]), int'(model[1]));

    // R13: after master NACK the line stays released until stop
    bstart; tx_byte({4'b1010, SEL, 1'b1}, ack);
    rx_byte(1'b0, d);
    check("R13 first byte", int'(d), int'(model[2]));
    hold_viol = 0;
    for (int i = 0; i < 9; i++) begin
      sda_drv = 1'b1; qwait; scl_drv = 1'b1; qwait;
      if (!sda_line) hold_viol++;
      scl_drv = 1'b0; qwait;
    end
    bstop;
    check("R13 released after nack", hold_viol, 0);

    // R2: repeated start drops a partial byte; no data stored, no busy
    bstart;
    tx_byte({4'b1010, SEL, 1'b0}, ack);
    tx_byte(8'h80, ack);
    for (int i = 0; i < 4; i++) tx_bit(1'b1);
    bstart;
    tx_byte({4'b1010, SEL, 1'b1}, ack);
    rx_byte(1'b0, d);
    bstop;
    check("R2 read after abort", int'(d), int'(model[8'h80]));
    bstart; tx_byte({4'b1010, SEL, 1'b0}, ack); bstop;
    check("R2 no busy after abort", int'(ack), 1);

    check("R3 oe stable while clock high", r3_viol, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule